// File: doc/BRIEF.md
# Graded PLL Unlock Detector

This block watches the phase-error pulse of a PLL phase comparator and measures, in reference-clock cycles, how long each pulse stays high. It keeps one sticky flag per severity level. A level's flag goes high once a pulse runs longer than that level's threshold. The result is a graded view of how far the loop has slipped, not a single lock/unlock bit. Software or a supervisor reads the flags and clears them all at once with a one-cycle strobe.

A run counter counts consecutive high samples of the error input. It returns to zero on the first low sample and saturates at its maximum. A bank of comparators checks the counter against the per-level thresholds. The default thresholds are 4, 8, 16 and 24 reference cycles. With a 7.2 MHz reference these come to roughly 0.55, 1.11, 2.22 and 3.33 microseconds, and the times scale with the reference frequency. A set of flag registers holds each level until it is cleared.

Top module: `ulk_grade_top`

## Requirements
- R1: While reset is asserted, and after it is released with no error pulse seen, `grade_o` is 0.
- R2: The run length is the number of consecutive rising clock edges at which `phase_err_i` is sampled high. It restarts from zero after any edge at which `phase_err_i` is low.
- R3: Bit k of `grade_o` becomes 1 at the rising edge that samples the (TH_k+1)-th consecutive high value of `phase_err_i`. The defaults are TH = 4, 8, 16, 24 for bits 0, 1, 2, 3.
- R4: A pulse lasting exactly TH_k cycles, or fewer, does not set bit k.
- R5: A pulse longer than several thresholds sets every bit whose threshold it exceeds, not only the highest one.
- R6: A set bit stays 1 through later idle cycles and shorter pulses until a clear occurs.
- R7: `clear_i` sampled high at an edge with no new set condition makes `grade_o` 0 after that edge.
- R8: If a set condition for bit k and `clear_i` occur at the same edge, bit k is 1 after that edge.
- R9: The run counter saturates and does not wrap. A pulse far longer than the counter range keeps meeting every threshold, so a clear during it leaves all bits set.
- R10: Whenever bit k+1 of `grade_o` is 1, bit k is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_err_i | input | 1 | Phase comparator error pulse (up or down active) |
| clear_i | input | 1 | Clear strobe for all flags |
| grade_o | output | NUM_LVL | Sticky severity flags, bit 0 the shortest threshold |

## Verification
The assertions check the rules that hold on every cycle:
- the run counter steps, restarts and saturates (R2, R9);
- a set flag stays set unless cleared (R6);
- a clear with no error empties the flags (R7);
- a flag only rises after an error sample (R3);
- the flag ordering holds (R10).

The exact cycle at which each level sets, and the fact that a pulse of exactly the threshold length leaves its flag clear, are shown only by the bench. It sweeps every pulse length from zero past the largest threshold. The priority of set over clear at the same edge, and the no-wrap behaviour under a very long pulse, also rest on dedicated bench scenarios.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
   // Extract threshold number idx from a packed list of w-bit values.
   function automatic int unsigned lvl_th(input logic [255:0] packed_th, input int idx, input int w);
      int unsigned v;
      v = 0;
      for (int b = 0; b < w; b++) v |= int'(packed_th[idx*w + b]) << b;
      return v;
   endfunction
endpackage

// File: rtl/ulk_run_ctr.sv
module ulk_run_ctr #(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             err_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_o <= '0;
      else if (!err_i)        cnt_o <= '0;
      else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/ulk_lvl_cmp.sv
module ulk_lvl_cmp #(
   parameter int                         CNT_W   = 6,
   parameter int                         NUM_LVL = 4,
   parameter logic [NUM_LVL*CNT_W-1:0]   LVL_TH  = '0
) (
   input  logic               err_i,
   input  logic [CNT_W-1:0]   cnt_i,
   output logic [NUM_LVL-1:0] set_o
);
   for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      localparam logic [CNT_W-1:0] TH = LVL_TH[k*CNT_W +: CNT_W];
      // The sample being taken now is run number cnt_i+1; it exceeds TH when cnt_i >= TH.
      assign set_o[k] = err_i && (cnt_i >= TH);
   end
endmodule

// File: rtl/ulk_flag_bank.sv
module ulk_flag_bank #(
   parameter int NUM_LVL = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_LVL-1:0] set_i,
   input  logic               clear_i,
   output logic [NUM_LVL-1:0] flag_o
);
   for (genvar k = 0; k < NUM_LVL; k++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        flag_o[k] <= 1'b0;
         else if (set_i[k])  flag_o[k] <= 1'b1;   // set takes priority over clear
         else if (clear_i)   flag_o[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/ulk_grade_top.sv
module ulk_grade_top #(
   parameter int                       CNT_W   = 6,
   parameter int                       NUM_LVL = 4,
   parameter logic [NUM_LVL*CNT_W-1:0] LVL_TH  = {6'd24, 6'd16, 6'd8, 6'd4}
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               phase_err_i,
   input  logic               clear_i,
   output logic [NUM_LVL-1:0] grade_o
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   // Elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("ulk_grade_top: CNT_W out of range");
   end
   if (NUM_LVL < 1 || NUM_LVL * CNT_W > 256) begin : g_bad_n
      $error("ulk_grade_top: NUM_LVL out of range");
   end
   for (genvar k = 0; k < NUM_LVL; k++) begin : g_chk_th
      if (ulk_pkg::lvl_th(256'(LVL_TH), k, CNT_W) >= CNT_MAX) begin : g_big
         $error("ulk_grade_top: threshold must stay below the counter saturation value");
      end
      if (k > 0) begin : g_ord
         if (ulk_pkg::lvl_th(256'(LVL_TH), k, CNT_W) <= ulk_pkg::lvl_th(256'(LVL_TH), k-1, CNT_W)) begin : g_desc
            $error("ulk_grade_top: thresholds must strictly increase with level");
         end
      end
   end

   logic [CNT_W-1:0]   run_cnt;
   logic [NUM_LVL-1:0] lvl_set;

   ulk_run_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .err_i  (phase_err_i),
      .cnt_o  (run_cnt)
   );

   ulk_lvl_cmp #(.CNT_W(CNT_W), .NUM_LVL(NUM_LVL), .LVL_TH(LVL_TH)) u_cmp (
      .err_i (phase_err_i),
      .cnt_i (run_cnt),
      .set_o (lvl_set)
   );

   ulk_flag_bank #(.NUM_LVL(NUM_LVL)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (lvl_set),
      .clear_i (clear_i),
      .flag_o  (grade_o)
   );
endmodule

// File: rtl/ulk_grade_chk.sv
module ulk_grade_chk #(
   parameter int CNT_W   = 6,
   parameter int NUM_LVL = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               phase_err_i,
   input logic               clear_i,
   input logic [NUM_LVL-1:0] grade_o,
   input logic [CNT_W-1:0]   run_cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R2
   cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !phase_err_i |=> run_cnt == '0);
   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_err_i && run_cnt != CMAX) |=> run_cnt == CNT_W'($past(run_cnt) + 1'b1));
   // R9
   cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_err_i && run_cnt == CMAX) |=> run_cnt == CMAX);
   // R7
   clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i && !phase_err_i) |=> grade_o == '0);

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_bit
      // R6
      sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (grade_o[k] && !clear_i) |=> grade_o[k]);
      // R3
      rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(grade_o[k]) |-> $past(phase_err_i));
      if (k > 0) begin : g_ord
         // R10
         level_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grade_o[k] |-> grade_o[k-1]);
      end
   end
endmodule

bind ulk_grade_top ulk_grade_chk #(.CNT_W(CNT_W), .NUM_LVL(NUM_LVL)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .phase_err_i (phase_err_i),
   .clear_i     (clear_i),
   .grade_o     (grade_o),
   .run_cnt     (run_cnt)
);

// File: tb/sim_ulk_grade_top.sv
`timescale 1ns/1ps
module sim_ulk_grade_top;
   localparam int CW  = 6;
   localparam int NL  = 4;
   localparam int CMX = (1 << CW) - 1;
   localparam int TH [NL] = '{4, 8, 16, 24};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic err = 1'b0;
   logic clr = 1'b0;
   logic [NL-1:0] grade;

   int checks = 0;
   int errors = 0;
   int m_cnt = 0;
   logic [NL-1:0] m_exp = '0;

   always #10 clk = ~clk;

   ulk_grade_top u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .phase_err_i (err),
      .clear_i     (clr),
      .grade_o     (grade)
   );

   task automatic check(input logic [NL-1:0] exp, input string req);
      checks++;
      if (grade !== exp) begin
         errors++;
         $display("FAIL %s: grade actual %b expected %b at %0t", req, grade, exp, $time);
      end
   endtask

   // One clock: drive at negedge, model the edge, check at the next negedge.
   task automatic step(input logic e, input logic c, input string req);
      logic [NL-1:0] s;
      err = e;
      clr = c;
      @(posedge clk);
      for (int k = 0; k < NL; k++) s[k] = e && (m_cnt >= TH[k]);
      m_exp = (c ? '0 : m_exp) | s;
      m_cnt = e ? ((m_cnt + 1 > CMX) ? CMX : m_cnt + 1) : 0;
      @(negedge clk);
      check(m_exp, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      check('0, "R1 during reset");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, "R1 after release");
      step(0, 0, "R1 idle");

      // Sweep every pulse length through and past the largest threshold.
      for (int n = 0; n <= 30; n++) begin
         logic [NL-1:0] want;
         step(0, 1, "R7 clear before pulse");
         for (int i = 1; i <= n; i++) step(1, 0, "R3 set timing");
         step(0, 0, "R2 pulse end");
         step(0, 0, "R6 hold after pulse");
         for (int k = 0; k < NL; k++) want[k] = (n > TH[k]);
         for (int k = 0; k < NL; k++) begin
            checks++;
            if (grade[k] !== want[k]) begin
               errors++;
               if (n == TH[k])
                  $display("FAIL R4: bit %0d len %0d actual %b expected %b", k, n, grade[k], want[k]);
               else
                  $display("FAIL R5: bit %0d len %0d actual %b expected %b", k, n, grade[k], want[k]);
            end
         end
      end

      // R2: broken pulses never accumulate across low gaps.
      step(0, 1, "R7 clear");
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < 4; i++) step(1, 0, "R2 split pulse");
         step(0, 0, "R2 gap");
      end

      // R6: flags survive short pulses and idle time.
      for (int i = 0; i < 26; i++) step(1, 0, "R5 full pulse");
      step(0, 0, "R6 end");
      for (int r = 0; r < 5; r++) begin
         step(1, 0, "R6 short pulse");
         step(1, 0, "R6 short pulse");
         for (int i = 0; i < 4; i++) step(0, 0, "R6 idle");
      end
      check(4'b1111, "R6 all retained");
      step(0, 1, "R7 clear all");
      check(4'b0000, "R7 cleared");

      // R8: clear at the same edge as active set conditions.
      for (int i = 1; i <= 30; i++) step(1, (i == 20), "R8 set beats clear");
      step(0, 0, "R8 end");
      check(4'b1111, "R8 final");
      step(0, 1, "R7 clear");
      for (int i = 1; i <= 20; i++) step(1, (i == 20), "R8 partial");
      check(4'b0111, "R8 level pattern");

      // R9: very long pulse, clear late in it.
      step(0, 1, "R7 clear");
      for (int i = 1; i <= 100; i++) step(1, (i == 80), "R9 saturation");
      check(4'b1111, "R9 no wrap");
      step(0, 0, "R9 end");
      step(0, 1, "R7 final clear");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule